// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block gathers twenty-four active-low interrupt request lines and turns them into a single 7-bit vector number for a CPU. It also gives one strobe that marks the request as fast and another that marks it as normal. The lines come from three groups. Eight are external lines from a companion port unit. Seven come from each of two peripheral devices, carried as that device's requests 7 down to 1. The last two are UART lines. Every line passes through a two-flop synchronizer. The live, synchronized levels can be read back through two read-only source registers on a 16-bit register bus.

Software controls which sources take part through two enable registers. A fast-enable register, which has bits only for the external lines, selects which of those lines count as fast requests. On each clock the block picks the winning request among those that are enabled and pending. Any fast request wins over every normal request. Within a class, the larger vector number wins. The result is registered onto the vector and strobe outputs. A pending request is removed only at its source: the block holds no latched state for it.

Top module: `irq_vec_ctrl`

## Requirements
- R1: Source lines are active low. A source status bit reads 0 while its line is pending and 1 while it is idle. A change on a line appears in the source register after exactly two clock edges (two-flop synchronizer).
- R2: Register map. Offset 0x0 is source register A, read-only: bits 15..8 hold device-B requests 7..1 in bits 15..9 and UART B in bit 8. Offset 0x2 is source register B, read-only: bits 15..8 hold external lines 7..0, bits 7..1 hold device-A requests 7..1, and bit 0 holds UART A. Offsets 0x4 and 0x6 are enable registers A and B, with the same bit layouts as source registers A and B. Offset 0xA is the fast-enable register, with bits 15..8 for external lines 7..0.
- R3: Fixed vectors. External lines 7..0 give 63..56. Device-A requests 7..1 give 55..49. UART A gives 48. Device-B requests 7..1 give 47..41. UART B gives 40. No vector below 40 is ever produced.
- R4: Among the enabled, pending normal requests, the one with the largest vector number is presented.
- R5: An enable bit of 1 passes its source. An enable bit of 0 masks it, so that source never reaches the vector or either strobe.
- R6: A fast-enable bit of 1 classes its external line as fast. The highest enabled, pending fast request is presented with fast_req high and norm_req low, and it wins over every normal request. Only external lines can be fast.
- R7: When no enabled request is pending, vec is 0 and both strobes are low. fast_req and norm_req are never high together.
- R8: Reserved bits read as 0 and ignore writes. This covers the low bytes of source register A, enable register A and the fast-enable register, offset 0x8 and all unmapped offsets. Writes to the source registers have no effect.
- R9: Synchronous active-high reset clears all enable and fast-enable bits and drives the outputs to vec 0 with both strobes low.
- R10: The outputs are registered. After an enable or fast-enable write, the outputs change on the clock edge after the edge that performs the write, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_req_n | input | 8 | External request lines 7..0, active low |
| dva_req_n | input | 7 | Device A requests 7..1 on bits 6..0, active low |
| dvb_req_n | input | 7 | Device B requests 7..1 on bits 6..0, active low |
| uart_a_n | input | 1 | UART A request, active low |
| uart_b_n | input | 1 | UART B request, active low |
| reg_addr | input | 4 | Register byte offset |
| reg_wen | input | 1 | Register write enable |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| vec | output | 7 | Vector number of the winning request, 0 when idle |
| fast_req | output | 1 | Winning request is fast |
| norm_req | output | 1 | Winning request is normal |

## Verification
The bench targets a fast external line that sits below a pending normal external line. A design that ranked by vector number alone would present the normal line instead of the fast one. It clears the enable bit of a source that is still pending, which would expose a mask applied after the encoder, and it writes ones into every reserved bit and into the read-only source offsets, which would catch storage or decode that leaks. It also counts edges around a synchronizer and around an enable write, so a missing flop or an extra flop shows up as a reading taken one cycle early or late.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 4;
  localparam int VEC_W    = 7;
  localparam int NEXT     = 8;   // external lines, the only fast-capable group
  localparam int NDEV     = 7;   // requests 7..1 per peripheral device
  localparam int NSRC     = NEXT + 2 * NDEV + 2;
  localparam int VEC_BASE = 40;  // vector of pending-vector bit 0
  localparam int FAST_POS = NSRC - NEXT; // bit index of external line 0

  localparam logic [ADDR_W-1:0] OFS_SRC_A  = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_SRC_B  = 4'h2;
  localparam logic [ADDR_W-1:0] OFS_EN_A   = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_EN_B   = 4'h6;
  localparam logic [ADDR_W-1:0] OFS_FAST   = 4'hA;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 1,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= {W{RST_VAL}};
      sync_q <= {W{RST_VAL}};
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
    end
  end

  assign dout = sync_q;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  // highest set bit wins: later loop iterations override earlier ones
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_vec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wen,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NSRC-1:0]   src_lvl,
  output logic [NSRC-1:0]   en_map,
  output logic [NEXT-1:0]   fast_map,
  output logic [DATA_W-1:0] rdata
);
  localparam int LO_W = NSRC - DATA_W; // live width of the "A" registers

  logic [LO_W-1:0]   en_a_q;
  logic [DATA_W-1:0] en_b_q;
  logic [NEXT-1:0]   fast_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_a_q <= '0;
      en_b_q <= '0;
      fast_q <= '0;
    end else if (wen) begin
      unique case (addr)
        OFS_EN_A: en_a_q <= wdata[DATA_W-1 -: LO_W];
        OFS_EN_B: en_b_q <= wdata;
        OFS_FAST: fast_q <= wdata[DATA_W-1 -: NEXT];
        default:  ;
      endcase
    end
  end

  assign en_map   = {en_b_q, en_a_q};
  assign fast_map = fast_q;

  always_comb begin
    unique case (addr)
      OFS_SRC_A: rdata = {src_lvl[LO_W-1:0], {(DATA_W-LO_W){1'b0}}};
      OFS_SRC_B: rdata = src_lvl[NSRC-1:LO_W];
      OFS_EN_A:  rdata = {en_a_q, {(DATA_W-LO_W){1'b0}}};
      OFS_EN_B:  rdata = en_b_q;
      OFS_FAST:  rdata = {fast_q, {(DATA_W-NEXT){1'b0}}};
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NEXT-1:0]   ext_req_n,
  input  logic [NDEV-1:0]   dva_req_n,
  input  logic [NDEV-1:0]   dvb_req_n,
  input  logic              uart_a_n,
  input  logic              uart_b_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wen,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [VEC_W-1:0]  vec,
  output logic              fast_req,
  output logic              norm_req
);
  localparam int NIW = $clog2(NSRC);
  localparam int FIW = $clog2(NEXT);

  // pending-vector order: bit i carries vector VEC_BASE + i
  logic [NSRC-1:0] raw_n, src_lvl, en_map, pend, norm_cand;
  logic [NEXT-1:0] fast_map, fast_cand;
  logic            f_any, n_any;
  logic [FIW-1:0]  f_idx;
  logic [NIW-1:0]  n_idx;

  assign raw_n = {ext_req_n, dva_req_n, uart_a_n, dvb_req_n, uart_b_n};

  irq_sync #(.W(NSRC), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .din(raw_n), .dout(src_lvl)
  );

  irq_regs u_regs (
    .clk(clk), .rst(rst), .addr(reg_addr), .wen(reg_wen), .wdata(reg_wdata),
    .src_lvl(src_lvl), .en_map(en_map), .fast_map(fast_map), .rdata(reg_rdata)
  );

  assign pend      = ~src_lvl & en_map;
  assign fast_cand = pend[NSRC-1 -: NEXT] & fast_map;
  assign norm_cand = pend & ~{fast_map, {FAST_POS{1'b0}}};

  irq_prio_enc #(.N(NEXT)) u_fast_enc (.req(fast_cand), .any(f_any), .idx(f_idx));
  irq_prio_enc #(.N(NSRC)) u_norm_enc (.req(norm_cand), .any(n_any), .idx(n_idx));

  logic [VEC_W-1:0] vec_d;
  always_comb begin
    if (f_any)      vec_d = VEC_W'(VEC_BASE + FAST_POS) + VEC_W'(f_idx);
    else if (n_any) vec_d = VEC_W'(VEC_BASE) + VEC_W'(n_idx);
    else            vec_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec      <= '0;
      fast_req <= 1'b0;
      norm_req <= 1'b0;
    end else begin
      vec      <= vec_d;
      fast_req <= f_any;
      norm_req <= n_any & ~f_any;
    end
  end
endmodule

// File: rtl/irq_vec_chk.sv
module irq_vec_chk
  import irq_vec_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [VEC_W-1:0]  vec,
  input logic              fast_req,
  input logic              norm_req
);
  a_r7_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(fast_req && norm_req));

  a_r7_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !(fast_req || norm_req) |-> vec == '0);

  a_r3_vec_range: assert property (@(posedge clk) disable iff (rst)
    (fast_req || norm_req) |-> (vec >= VEC_W'(VEC_BASE) && vec <= VEC_W'(VEC_BASE + NSRC - 1)));

  a_r6_fast_ext_only: assert property (@(posedge clk) disable iff (rst)
    fast_req |-> vec >= VEC_W'(VEC_BASE + FAST_POS));

  a_r8_src_a_low_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == OFS_SRC_A) |-> reg_rdata[7:0] == 8'h00);

  a_r8_fast_low_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == OFS_FAST) |-> reg_rdata[7:0] == 8'h00);
endmodule

bind irq_vec_ctrl irq_vec_chk u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .vec(vec), .fast_req(fast_req), .norm_req(norm_req)
);

// File: tb/sim_irq_vec_ctrl.sv
module sim_irq_vec_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  ext_req_n = 8'hFF;
  logic [6:0]  dva_req_n = 7'h7F;
  logic [6:0]  dvb_req_n = 7'h7F;
  logic        uart_a_n = 1'b1;
  logic        uart_b_n = 1'b1;
  logic [3:0]  reg_addr = 4'h0;
  logic        reg_wen = 1'b0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic [6:0]  vec;
  logic        fast_req, norm_req;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  irq_vec_ctrl u0 (
    .clk(clk), .rst(rst), .ext_req_n(ext_req_n), .dva_req_n(dva_req_n),
    .dvb_req_n(dvb_req_n), .uart_a_n(uart_a_n), .uart_b_n(uart_b_n),
    .reg_addr(reg_addr), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .vec(vec), .fast_req(fast_req), .norm_req(norm_req)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] outs();
    return {7'd0, norm_req, fast_req, vec};
  endfunction

  function automatic logic [15:0] ov(input logic n, input logic f, input int v);
    return {7'd0, n, f, 7'(v)};
  endfunction

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    @(posedge clk); #1;
    reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(4'h0, d); check("R2 src A idle", d, 16'hFF00);
    rd(4'h2, d); check("R2 src B idle", d, 16'hFFFF);
    rd(4'h4, d); check("R9 en A reset", d, 16'h0000);
    rd(4'h6, d); check("R9 en B reset", d, 16'h0000);
    rd(4'hA, d); check("R9 fast reset", d, 16'h0000);
    check("R9 outputs after reset", outs(), ov(0, 0, 0));
  endtask

  task automatic t_sync_view();
    logic [15:0] d;
    @(negedge clk);
    reg_addr = 4'h2;
    ext_req_n[3] = 1'b0; dva_req_n[4] = 1'b0; uart_b_n = 1'b0;
    @(posedge clk); #1;
    check("R1 not visible after one edge", reg_rdata, 16'hFFFF);
    @(posedge clk); #1;
    check("R1 src B after two edges", reg_rdata, 16'hF7DF);
    rd(4'h0, d); check("R2 src A uart B low", d, 16'hFE00);
    settle();
    check("R5 all masked stays idle", outs(), ov(0, 0, 0));
  endtask

  task automatic t_priority();
    wr(4'h4, 16'hFF00);
    wr(4'h6, 16'hFFFF);
    settle(); check("R4 ext3 wins", outs(), ov(1, 0, 59));
    ext_req_n[3] = 1'b1;
    settle(); check("R3 R4 dev A req5", outs(), ov(1, 0, 53));
    dva_req_n[4] = 1'b1;
    settle(); check("R3 uart B", outs(), ov(1, 0, 40));
    uart_a_n = 1'b0;
    settle(); check("R3 uart A", outs(), ov(1, 0, 48));
    dvb_req_n[6] = 1'b0;
    settle(); check("R4 uart A over dev B req7", outs(), ov(1, 0, 48));
    uart_a_n = 1'b1;
    settle(); check("R3 dev B req7", outs(), ov(1, 0, 47));
    dvb_req_n[6] = 1'b1; uart_b_n = 1'b1;
    settle(); check("R7 idle when none pending", outs(), ov(0, 0, 0));
  endtask

  task automatic t_mask();
    dva_req_n[4] = 1'b0; uart_b_n = 1'b0;
    wr(4'h6, 16'hFFDF);
    settle(); check("R5 masked dev A req5 skipped", outs(), ov(1, 0, 40));
    wr(4'h4, 16'h0000);
    settle(); check("R5 uart B masked", outs(), ov(0, 0, 0));
    dva_req_n[4] = 1'b1; uart_b_n = 1'b1;
    wr(4'h4, 16'hFF00);
    wr(4'h6, 16'hFFFF);
  endtask

  task automatic t_fast();
    logic [15:0] d;
    wr(4'hA, 16'h04FF);
    rd(4'hA, d); check("R8 fast low byte reserved", d, 16'h0400);
    ext_req_n[2] = 1'b0; ext_req_n[6] = 1'b0;
    settle(); check("R6 fast ext2 beats normal ext6", outs(), ov(0, 1, 58));
    ext_req_n[2] = 1'b1; dva_req_n[6] = 1'b0;
    settle(); check("R6 normal ext6 after fast drops", outs(), ov(1, 0, 62));
    wr(4'h6, 16'hFBFF);
    ext_req_n[2] = 1'b0;
    settle(); check("R5 masked fast line ignored", outs(), ov(1, 0, 62));
    ext_req_n[2] = 1'b1;
    wr(4'h6, 16'hFFFF);
    settle();
  endtask

  task automatic t_latency();
    wr(4'h6, 16'h00FF);
    check("R10 no change at write edge", outs(), ov(1, 0, 62));
    @(posedge clk); #1;
    check("R10 change one edge later", outs(), ov(1, 0, 55));
    ext_req_n[6] = 1'b1; dva_req_n[6] = 1'b1;
    settle();
  endtask

  task automatic t_reserved();
    logic [15:0] d;
    wr(4'h8, 16'hFFFF);
    rd(4'h8, d); check("R8 offset 0x8 reads zero", d, 16'h0000);
    wr(4'h0, 16'h1234);
    rd(4'h0, d); check("R8 src A ignores write", d, 16'hFF00);
    wr(4'h2, 16'h0000);
    rd(4'h2, d); check("R8 src B ignores write", d, 16'hFFFF);
    wr(4'h4, 16'hFFFF);
    rd(4'h4, d); check("R8 en A low byte reserved", d, 16'hFF00);
    check("R7 idle after reserved writes", outs(), ov(0, 0, 0));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_sync_view();
    t_priority();
    t_mask();
    t_fast();
    t_latency();
    t_reserved();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule